// File: doc/BRIEF.md
# Flash Bus Operation Mode Controller

This block is the control front end of a parallel NOR-style flash memory model. Each rising clock edge it samples the active-low chip enable, output enable, write enable, address-latch strobe and device reset pins, together with the busy flag of the program/erase engine. From those samples it picks one bus operation: reset, standby, read, write, address latch, output disable, or a held-active state. That choice sets the data-bus drive and capture enables, whether the WAIT pin is driven, and a low-power indication.

The block also handles the two cases where the engine's busy flag matters. A deselect that arrives during a program/erase keeps the device active until the engine finishes, and only then does it enter standby. A device reset that arrives during a program/erase sends the engine a one-cycle abort request and raises a sticky contents-invalid flag, which a clear input removes. The address is captured while the latch strobe is low and is kept for later reads that leave the strobe high.

Top module: `flash_busop_ctrl`

## Requirements
- R1: With device reset (`rp_n`) sampled low, `op_code` is 0 (reset), `dq_drive`, `dq_capture` and `wait_oe` are 0 and `low_power` is 1, whatever the other control pins are. Every control pin reaches the outputs through one register, so the outputs follow a pin change after one rising edge.
- R2: With `rp_n` high, `ce_n` high and `busy` low, `op_code` is 1 (standby), `low_power` is 1, and `dq_drive`, `dq_capture` and `wait_oe` are 0 for any `oe_n` and `we_n`.
- R3: With `rp_n` high, `ce_n` high and `busy` high, `op_code` is 6 (held active), `low_power` is 0, and no bus drive or capture is enabled. The block moves to standby (code 1) in the first cycle in which `busy` is sampled low.
- R4: `ce_n`=0, `oe_n`=0, `we_n`=1, `adv_n`=1 gives `op_code` 2 (read) with `dq_drive`=1 and `wait_oe`=1.
- R5: `ce_n`=0, `oe_n`=1, `we_n`=0, `adv_n`=1 gives `op_code` 3 (write) with `dq_capture`=1, `dq_drive`=0 and `wait_oe`=0.
- R6: `ce_n`=0 with `adv_n`=0 gives `op_code` 4 (address latch) and takes priority over the read, write and disable decodes. `dq_drive` equals the inverse of `oe_n`, `wait_oe` is 0, and the address sampled with the strobe appears on `addr_out` with `addr_valid`=1 one edge after the strobe appears on `op_code`.
- R7: `ce_n`=0, `adv_n`=1 with `oe_n` and `we_n` both high, or both low, gives `op_code` 5 (output disable) with no drive, capture or WAIT.
- R8: `wait_out` equals `wait_req` when `wait_pol` is 1 and its inverse when `wait_pol` is 0, without any register in between.
- R9: `addr_out` changes only in the cycle after an address-latch decode, so reads with `adv_n` high reuse the stored address. A reset decode clears `addr_valid` one edge later.
- R10: `abort_req` is 1 for exactly one cycle when `rp_n` is sampled low after being sampled high while `busy` is sampled high. A falling `rp_n` while `busy` is low gives no pulse.
- R11: `contents_invalid` rises the edge after an `abort_req` pulse and stays at 1 until `inv_clr` is high at a rising edge with no abort pending. A pending abort wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| adv_n | input | 1 | Address-latch strobe, active low |
| rp_n | input | 1 | Device reset pin, active low |
| busy | input | 1 | Program/erase engine is running |
| wait_pol | input | 1 | WAIT polarity: 1 active high, 0 active low |
| wait_req | input | 1 | Wait condition from the burst logic |
| inv_clr | input | 1 | Clears the contents-invalid flag |
| addr_in | input | AW | Address bus |
| op_code | output | 3 | Current bus operation code |
| dq_drive | output | 1 | Data bus drives read data |
| dq_capture | output | 1 | Data bus is taken as write input |
| wait_oe | output | 1 | WAIT pin is driven (not high impedance) |
| wait_out | output | 1 | WAIT pin level with polarity applied |
| low_power | output | 1 | Standby or reset power level |
| addr_out | output | AW | Stored address |
| addr_valid | output | 1 | A latched address is held |
| abort_req | output | 1 | One-cycle abort request to the engine |
| contents_invalid | output | 1 | Array contents are no longer valid |

## Verification
The hardest case to reach is the abort: the device reset pin has to fall in a cycle in which the sampled busy flag is still high, with the previous reset sample high, and the one-cycle pulse has to be seen before the sticky flag follows on the next edge. The bench runs a write with busy held for several cycles, drops reset at a falling edge, and samples once per cycle for the pulse, then the flag, then the clear. A matching fall with busy low checks that no pulse is produced, and a deselect while busy covers the deferred standby.

// File: rtl/flash_busop_pkg.sv
package flash_busop_pkg;

  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_STANDBY = 3'd1,
    OP_READ    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_LATCH   = 3'd4,
    OP_ODIS    = 3'd5,
    OP_HOLD    = 3'd6
  } busop_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic adv_n;
    logic rp_n;
    logic busy;
  } ctl_pins_s;

  localparam ctl_pins_s CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                     adv_n: 1'b1, rp_n: 1'b0, busy: 1'b0};

endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = (STAGES < 2) ? 1 : STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/flash_busop_sampler.sv
module flash_busop_sampler
  import flash_busop_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_pins_s     pins_i,
  input  logic [AW-1:0] addr_i,
  output ctl_pins_s     pins_q,
  output logic          rp_prev_q,
  output logic [AW-1:0] addr_q
);
  ctl_pins_s     pins_d;
  logic          rp_prev_d;
  logic [AW-1:0] addr_d;

  always_comb begin
    pins_d    = pins_i;
    rp_prev_d = pins_q.rp_n;
    addr_d    = addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q    <= CTL_IDLE;
      rp_prev_q <= 1'b0;
      addr_q    <= '0;
    end else begin
      pins_q    <= pins_d;
      rp_prev_q <= rp_prev_d;
      addr_q    <= addr_d;
    end
  end
endmodule

// File: rtl/flash_busop_decode.sv
module flash_busop_decode
  import flash_busop_pkg::*;
(
  input  ctl_pins_s pins,
  output busop_e    op,
  output logic      dq_drive,
  output logic      dq_capture,
  output logic      wait_oe,
  output logic      low_power
);
  always_comb begin
    if (!pins.rp_n)                       op = OP_RESET;
    else if (pins.ce_n)                   op = pins.busy ? OP_HOLD : OP_STANDBY;
    else if (!pins.adv_n)                 op = OP_LATCH;
    else if (!pins.oe_n && pins.we_n)     op = OP_READ;
    else if (pins.oe_n && !pins.we_n)     op = OP_WRITE;
    else                                  op = OP_ODIS;
  end

  always_comb begin
    dq_drive   = 1'b0;
    dq_capture = 1'b0;
    wait_oe    = 1'b0;
    low_power  = 1'b0;
    unique case (op)
      OP_RESET:   low_power  = 1'b1;
      OP_STANDBY: low_power  = 1'b1;
      OP_READ: begin
        dq_drive = 1'b1;
        wait_oe  = 1'b1;
      end
      OP_WRITE:   dq_capture = 1'b1;
      OP_LATCH:   dq_drive   = ~pins.oe_n;
      OP_ODIS:    dq_drive   = 1'b0;
      OP_HOLD:    low_power  = 1'b0;
      default:    low_power  = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_busop_addr_hold.sv
module flash_busop_addr_hold
  import flash_busop_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  busop_e        op,
  input  logic [AW-1:0] addr_s,
  output logic [AW-1:0] addr_q,
  output logic          valid_q
);
  logic          cap_en;
  logic [AW-1:0] addr_d;
  logic          valid_d;

  always_comb begin
    cap_en  = (op == OP_LATCH);
    addr_d  = cap_en ? addr_s : addr_q;
    valid_d = valid_q;
    if (op == OP_RESET) valid_d = 1'b0;
    else if (cap_en)    valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      valid_q <= valid_d;
    end
  end
endmodule

// File: rtl/flash_busop_abort.sv
module flash_busop_abort (
  input  logic clk,
  input  logic rst_n,
  input  logic rp_n_s,
  input  logic rp_prev_s,
  input  logic busy_s,
  input  logic inv_clr,
  output logic abort_req,
  output logic invalid_q
);
  logic invalid_d;

  always_comb begin
    abort_req = rp_prev_s & ~rp_n_s & busy_s;
    invalid_d = invalid_q;
    if (abort_req)    invalid_d = 1'b1;
    else if (inv_clr) invalid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) invalid_q <= 1'b0;
    else        invalid_q <= invalid_d;
  end
endmodule

// File: rtl/flash_busop_ctrl.sv
module flash_busop_ctrl
  import flash_busop_pkg::*;
#(
  parameter int AW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          adv_n,
  input  logic          rp_n,
  input  logic          busy,
  input  logic          wait_pol,
  input  logic          wait_req,
  input  logic          inv_clr,
  input  logic [AW-1:0] addr_in,
  output logic [2:0]    op_code,
  output logic          dq_drive,
  output logic          dq_capture,
  output logic          wait_oe,
  output logic          wait_out,
  output logic          low_power,
  output logic [AW-1:0] addr_out,
  output logic          addr_valid,
  output logic          abort_req,
  output logic          contents_invalid
);
  logic          rst_int_n;
  ctl_pins_s     pins_raw;
  ctl_pins_s     pins_s;
  logic          rp_prev_s;
  logic [AW-1:0] addr_s;
  busop_e        op;

  flash_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  always_comb begin
    pins_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n,
                 adv_n: adv_n, rp_n: rp_n, busy: busy};
  end

  flash_busop_sampler #(.AW(AW)) u_smp (
    .clk(clk), .rst_n(rst_int_n), .pins_i(pins_raw), .addr_i(addr_in),
    .pins_q(pins_s), .rp_prev_q(rp_prev_s), .addr_q(addr_s)
  );

  flash_busop_decode u_dec (
    .pins(pins_s), .op(op), .dq_drive(dq_drive), .dq_capture(dq_capture),
    .wait_oe(wait_oe), .low_power(low_power)
  );

  flash_busop_addr_hold #(.AW(AW)) u_adr (
    .clk(clk), .rst_n(rst_int_n), .op(op), .addr_s(addr_s),
    .addr_q(addr_out), .valid_q(addr_valid)
  );

  flash_busop_abort u_abt (
    .clk(clk), .rst_n(rst_int_n), .rp_n_s(pins_s.rp_n), .rp_prev_s(rp_prev_s),
    .busy_s(pins_s.busy), .inv_clr(inv_clr), .abort_req(abort_req),
    .invalid_q(contents_invalid)
  );

  // polarity selection is a plain mux on the live request
  generate
    if (1) begin : g_wait
      assign wait_out = wait_pol ? wait_req : ~wait_req;
    end
  endgenerate

  assign op_code = op;
endmodule

// File: rtl/flash_busop_chk.sv
module flash_busop_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op_code,
  input logic          dq_drive,
  input logic          dq_capture,
  input logic          wait_oe,
  input logic          low_power,
  input logic [AW-1:0] addr_out,
  input logic          abort_req,
  input logic          contents_invalid
);
  // R1: reset mode keeps the bus quiet at low power
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd0) |-> (low_power && !dq_drive && !wait_oe && !dq_capture));

  // R2: standby never drives or captures
  a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd1) |-> (!dq_drive && !wait_oe && !dq_capture));

  // R3: held-active state is not low power
  a_r3_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd6) |-> (!low_power && !dq_drive));

  // R4: WAIT is only driven together with read data
  a_r4_wait_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    wait_oe |-> dq_drive);

  // R9: stored address only moves after a latch decode
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code != 3'd4) |=> $stable(addr_out));

  // R10: abort request is a single-cycle pulse
  a_r10_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req);

  // R11: invalid flag follows the abort pulse
  a_r11_invalid_set: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> contents_invalid);

  // R5: capture and drive never together
  a_r5_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_drive && dq_capture));
endmodule

bind flash_busop_ctrl flash_busop_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_code(op_code), .dq_drive(dq_drive),
  .dq_capture(dq_capture), .wait_oe(wait_oe), .low_power(low_power),
  .addr_out(addr_out), .abort_req(abort_req),
  .contents_invalid(contents_invalid)
);

// File: tb/flash_busop_ctrl_test.sv
module flash_busop_ctrl_test;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic ce_n, oe_n, we_n, adv_n, rp_n, busy;
  logic wait_pol, wait_req, inv_clr;
  logic [AW-1:0] addr_in;
  logic [2:0] op_code;
  logic dq_drive, dq_capture, wait_oe, wait_out, low_power;
  logic [AW-1:0] addr_out;
  logic addr_valid, abort_req, contents_invalid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  flash_busop_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .adv_n(adv_n), .rp_n(rp_n), .busy(busy), .wait_pol(wait_pol),
    .wait_req(wait_req), .inv_clr(inv_clr), .addr_in(addr_in),
    .op_code(op_code), .dq_drive(dq_drive), .dq_capture(dq_capture),
    .wait_oe(wait_oe), .wait_out(wait_out), .low_power(low_power),
    .addr_out(addr_out), .addr_valid(addr_valid), .abort_req(abort_req),
    .contents_invalid(contents_invalid)
  );

  // row: req[3:0], ce,oe,we,adv,rp,busy, op[2:0], drive,cap,woe,lp
  localparam int NV = 14;
  localparam logic [16:0] VEC [NV] = '{
    {4'd4,  6'b001110, 3'd2, 4'b1010},  // R4 read
    {4'd5,  6'b010110, 3'd3, 4'b0100},  // R5 write
    {4'd7,  6'b011110, 3'd5, 4'b0000},  // R7 disable, both high
    {4'd7,  6'b000110, 3'd5, 4'b0000},  // R7 disable, both low
    {4'd6,  6'b001010, 3'd4, 4'b1000},  // R6 latch, oe low drives
    {4'd6,  6'b011010, 3'd4, 4'b0000},  // R6 latch, oe high quiet
    {4'd2,  6'b100110, 3'd1, 4'b0001},  // R2 standby, oe/we low
    {4'd2,  6'b101110, 3'd1, 4'b0001},  // R2 standby, read-like
    {4'd3,  6'b101111, 3'd6, 4'b0000},  // R3 deselect while busy
    {4'd3,  6'b101110, 3'd1, 4'b0001},  // R3 busy clears -> standby
    {4'd1,  6'b001100, 3'd0, 4'b0001},  // R1 reset over read
    {4'd1,  6'b111100, 3'd0, 4'b0001},  // R1 reset over deselect
    {4'd4,  6'b001110, 3'd2, 4'b1010},  // R4 read after reset
    {4'd5,  6'b010111, 3'd3, 4'b0100}   // R5 write while busy
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pins(input logic [5:0] v);
    {ce_n, oe_n, we_n, adv_n, rp_n, busy} = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pins(6'b111110);
    wait_pol = 1'b1; wait_req = 1'b0; inv_clr = 1'b0; addr_in = '0;
    repeat (3) @(negedge clk);
    // R1 block reset state
    chk(op_code == 3'd0 && low_power && !dq_drive && !wait_oe, "R1 reset op/lp",
        {op_code, low_power, dq_drive, wait_oe}, {3'd0, 3'b100});
    chk(!addr_valid && !contents_invalid && !abort_req, "R11 reset flags",
        {addr_valid, contents_invalid, abort_req}, 3'b000);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(op_code == 3'd1, "R2 idle standby", op_code, 3'd1);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      pins(v[12:7]);
      tick();
      chk(op_code == v[6:4], $sformatf("R%0d row %0d op", v[16:13], i), op_code, v[6:4]);
      chk({dq_drive, dq_capture, wait_oe, low_power} == v[3:0],
          $sformatf("R%0d row %0d enables", v[16:13], i),
          {dq_drive, dq_capture, wait_oe, low_power}, v[3:0]);
      chk(!abort_req, $sformatf("R10 row %0d no abort", i), abort_req, 0);
    end

    // R8 WAIT polarity during a read
    pins(6'b001110);
    tick();
    wait_pol = 1'b1; wait_req = 1'b1; #1;
    chk(wait_out == 1'b1, "R8 high polarity asserted", wait_out, 1);
    wait_pol = 1'b0; #1;
    chk(wait_out == 1'b0, "R8 low polarity asserted", wait_out, 0);
    wait_req = 1'b0; #1;
    chk(wait_out == 1'b1, "R8 low polarity idle", wait_out, 1);
    wait_pol = 1'b1; #1;
    chk(wait_out == 1'b0, "R8 high polarity idle", wait_out, 0);

    // R6 latch capture and R9 reuse
    pins(6'b011010); addr_in = 16'hA5C3;
    tick();
    addr_in = 16'h1234;
    pins(6'b001110);
    tick();
    chk(addr_out == 16'hA5C3 && addr_valid, "R6 latched address",
        {addr_valid, addr_out}, {1'b1, 16'hA5C3});
    repeat (3) tick();
    chk(addr_out == 16'hA5C3 && op_code == 3'd2, "R9 reuse on read",
        {op_code, addr_out}, {3'd2, 16'hA5C3});
    pins(6'b001100);
    repeat (2) tick();
    chk(!addr_valid, "R9 reset clears valid", addr_valid, 0);

    // R10 / R11 abort during program/erase
    pins(6'b010111);
    repeat (3) tick();
    pins(6'b010101);
    tick();
    chk(abort_req && !contents_invalid, "R10 abort pulse",
        {abort_req, contents_invalid}, 2'b10);
    tick();
    chk(!abort_req && contents_invalid, "R11 flag set, pulse ended",
        {abort_req, contents_invalid}, 2'b01);
    pins(6'b010100);
    repeat (3) tick();
    pins(6'b011110);
    tick();
    chk(contents_invalid && !abort_req, "R11 flag sticky",
        {abort_req, contents_invalid}, 2'b01);
    inv_clr = 1'b1;
    tick();
    inv_clr = 1'b0;
    chk(!contents_invalid, "R11 clear", contents_invalid, 0);

    // R10 reset fall without busy: no abort
    pins(6'b011100);
    tick();
    chk(!abort_req, "R10 no pulse when idle", abort_req, 0);
    tick();
    chk(!contents_invalid, "R11 stays clear", contents_invalid, 0);

    // R11 abort wins over a simultaneous clear
    pins(6'b011111);
    repeat (2) tick();
    pins(6'b011101);
    inv_clr = 1'b1;
    tick();
    tick();
    inv_clr = 1'b0;
    chk(contents_invalid, "R11 abort over clear", contents_invalid, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule